// File: doc/BRIEF.md
# Multiphase Clock Synthesizer with Duty Control

This block is the digital back end of a multiphase clock generator. A ring oscillator supplies eight equally spaced phases. The block is modelled in discrete time: each tick of its clock stands for one phase step, which is one eighth of an oscillator period. From a 4-bit period word and a 3-bit duty word, the block works out which phase must carry the next rising and falling edge of a synthesized output clock. It toggles that output on each of those edges.

Two step accumulators run side by side. The rise path holds the absolute step number of the next rising edge, and the fall path holds that of the next falling edge. The low three bits of each accumulator are the phase select that a glitch-free phase multiplexer would use. The upper bits count whole oscillator cycles, so an edge lands on the correct tick. The fall path is placed a set number of steps after the rise. That gap sets the high time without changing the period. New settings are taken only at a rising edge of the output, so a change takes effect at once without loop relock and never cuts a pulse short. Illegal pairs are flagged and ignored.

Top module: `mcs_duty_synth`

## Requirements
- R1: While `rst` is high at a clock edge, `clk_out` goes low. The rise accumulator loads the captured period F, and the fall accumulator loads F plus the captured high time. The captured pair is the input pair if legal, else the defaults F=8 with duty word 0.
- R2: The output period is exactly F clock cycles for every legal duty word.
- R3: The output stays high for floor(F/2) − D cycles of each period, where D is the duty word. For example, F=15 with D=1 gives 6 high cycles, and F=2 gives 1.
- R4: After `rst` is deasserted, `clk_out` first goes high at the (F+1)th rising clock edge.
- R5: `sel_rise` equals the absolute step index of the next rising edge modulo 8. `sel_fall` equals that of the next falling edge modulo 8. On each rise, `sel_rise` advances by F modulo 8, and `sel_fall` becomes the rise step plus the high time, modulo 8.
- R6: The period and duty inputs are sampled only at the clock edge where `clk_out` rises. A change in mid-period does not alter the period in progress.
- R7: A pair is legal when F ≥ 2 and D ≤ floor(F/2) − 1. So F = 2 and F = 3 allow only D = 0. An illegal pair sampled at a rise is ignored, and the previous legal settings stay in force.
- R8: `cfg_err` is registered. One cycle after the inputs are presented, it is 1 when the pair is illegal and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one phase step per cycle |
| rst | input | 1 | Synchronous active-high reset |
| freq_in | input | 4 | Period in phase steps (F), legal 2 to 15 |
| dmode_in | input | 3 | Duty word (D), steps taken off half the period |
| sel_rise | output | 3 | Phase select of the next rising edge |
| sel_fall | output | 3 | Phase select of the next falling edge |
| clk_out | output | 1 | Synthesized clock level |
| cfg_err | output | 1 | Illegal period/duty pair at the inputs |

## Verification
A corrupted accumulator shows up on the phase select outputs in the very next cycle. It also moves an edge of `clk_out`, which a cycle-by-cycle reference model catches within one output period. A wrong capture point or a broken legality check changes the measured high and low counts of the period that follows the next rising edge. A stuck toggle stops `clk_out` from changing within at most fifteen cycles.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int FREQ_W  = 4;
  localparam int DUTY_W  = 3;
  localparam int PHASES  = 8;
  localparam int STEP_AW = 16;

  // a period/duty pair is usable when at least one high step remains
  function automatic bit pair_ok(int f, int d);
    return (f >= 2) && ((d + 1) <= (f / 2));
  endfunction
endpackage

// File: rtl/mcs_cfg_reg.sv
module mcs_cfg_reg #(
  parameter int FW    = mcs_pkg::FREQ_W,
  parameter int DW    = mcs_pkg::DUTY_W,
  parameter int DEF_F = 8,
  parameter int DEF_D = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [FW-1:0] freq_in,
  input  logic [DW-1:0] dmode_in,
  output logic [FW-1:0] cap_per,
  output logic [FW-1:0] cap_high,
  output logic          err_q
);
  localparam logic [FW-1:0] DEF_PER  = FW'(DEF_F);
  localparam logic [FW-1:0] DEF_HIGH = FW'(DEF_F / 2 - DEF_D);

  logic          in_ok;
  logic [FW-1:0] per_q, high_q;

  assign in_ok = mcs_pkg::pair_ok(int'(freq_in), int'(dmode_in));

  always_comb begin
    if (in_ok) begin
      cap_per  = freq_in;
      cap_high = (freq_in >> 1) - FW'(dmode_in);
    end else if (rst) begin
      cap_per  = DEF_PER;
      cap_high = DEF_HIGH;
    end else begin
      cap_per  = per_q;
      cap_high = high_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      per_q  <= cap_per;
      high_q <= cap_high;
    end
    err_q <= !in_ok;
  end

  // R7
  illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ok |=> (per_q == $past(per_q)) && (high_q == $past(high_q)));

  // R6
  midperiod_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(per_q) && $stable(high_q));

  // R3
  high_range_chk: assert property (@(posedge clk) disable iff (rst)
    (high_q >= FW'(1)) && (high_q < per_q));
endmodule

// File: rtl/mcs_step_path.sv
module mcs_step_path #(
  parameter int AW = mcs_pkg::STEP_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] rst_val,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] tick,
  output logic          hit,
  output logic [AW-1:0] acc_q
);
  always_ff @(posedge clk) begin
    if (rst)       acc_q <= rst_val;
    else if (load) acc_q <= base + step;
  end

  assign hit = (tick == acc_q);

  // R5
  ahead_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> (acc_q != tick));
endmodule

// File: rtl/mcs_edge_toggle.sv
module mcs_edge_toggle (
  input  logic clk,
  input  logic rst,
  input  logic ev_set,
  input  logic ev_clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q ^ (ev_set | ev_clr);
  end

  // R3
  rise_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    ev_set |=> q);

  // R3
  fall_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    ev_clr |=> !q);

  // R2
  no_clash_chk: assert property (@(posedge clk) disable iff (rst)
    !(ev_set && ev_clr));
endmodule

// File: rtl/mcs_duty_synth.sv
module mcs_duty_synth #(
  parameter int FW    = mcs_pkg::FREQ_W,
  parameter int DW    = mcs_pkg::DUTY_W,
  parameter int NPH   = mcs_pkg::PHASES,
  parameter int AW    = mcs_pkg::STEP_AW,
  parameter int DEF_F = 8,
  parameter int DEF_D = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [FW-1:0]          freq_in,
  input  logic [DW-1:0]          dmode_in,
  output logic [$clog2(NPH)-1:0] sel_rise,
  output logic [$clog2(NPH)-1:0] sel_fall,
  output logic                   clk_out,
  output logic                   cfg_err
);
  localparam int SEL_W = $clog2(NPH);
  localparam int NPATH = 2;

  logic [AW-1:0] tick_q;
  logic [FW-1:0] cap_per, cap_high;
  logic [AW-1:0] per_ext, high_ext;
  logic [AW-1:0] acc [NPATH];
  logic [NPATH-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst) tick_q <= '0;
    else     tick_q <= tick_q + AW'(1);
  end

  mcs_cfg_reg #(.FW(FW), .DW(DW), .DEF_F(DEF_F), .DEF_D(DEF_D)) u_cfg (
    .clk(clk), .rst(rst), .load(hit[0]),
    .freq_in(freq_in), .dmode_in(dmode_in),
    .cap_per(cap_per), .cap_high(cap_high), .err_q(cfg_err)
  );

  assign per_ext  = AW'(cap_per);
  assign high_ext = AW'(cap_high);

  // path 0 schedules rises, path 1 schedules falls; both reload on a rise
  for (genvar g = 0; g < NPATH; g++) begin : g_path
    logic [AW-1:0] step_g, rst_g;
    if (g == 0) begin : g_rise
      assign step_g = per_ext;
      assign rst_g  = per_ext;
    end else begin : g_fall
      assign step_g = high_ext;
      assign rst_g  = per_ext + high_ext;
    end
    mcs_step_path #(.AW(AW)) u_path (
      .clk(clk), .rst(rst), .load(hit[0]),
      .rst_val(rst_g), .base(acc[0]), .step(step_g),
      .tick(tick_q), .hit(hit[g]), .acc_q(acc[g])
    );
  end

  mcs_edge_toggle u_tog (
    .clk(clk), .rst(rst), .ev_set(hit[0]), .ev_clr(hit[1]), .q(clk_out)
  );

  assign sel_rise = acc[0][SEL_W-1:0];
  assign sel_fall = acc[1][SEL_W-1:0];

  // R2
  period_step_chk: assert property (@(posedge clk) disable iff (rst)
    hit[0] |=> ((acc[0] - $past(acc[0])) == $past(per_ext)));

  // R5
  fall_offset_chk: assert property (@(posedge clk) disable iff (rst)
    hit[0] |=> ((acc[1] - $past(acc[0])) == $past(high_ext)));
endmodule

// File: tb/mcs_duty_synth_bench.sv
module mcs_duty_synth_bench;
  localparam int AW = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] freq_in = 4'd8;
  logic [2:0] dmode_in = 3'd1;
  logic [2:0] sel_rise, sel_fall;
  logic       clk_out, cfg_err;

  int tests = 0, fails = 0, cycles = 0;
  bit chk_en = 1'b0;

  always #2.5 clk = ~clk;

  mcs_duty_synth u_mcs_duty_synth (
    .clk(clk), .rst(rst), .freq_in(freq_in), .dmode_in(dmode_in),
    .sel_rise(sel_rise), .sel_fall(sel_fall), .clk_out(clk_out), .cfg_err(cfg_err)
  );

  function automatic bit ok_pair(int f, int d);
    return (f >= 2) && (d <= f / 2 - 1);
  endfunction

  function automatic int hi_of(int f, int d);
    return f / 2 - d;
  endfunction

  task automatic check(bit cond, string req, int act, int exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycle reference model built from the requirements
  logic [AW-1:0] m_t, m_rise, m_fall;
  int  m_f = 8, m_h = 4;
  bit  m_out, m_err;

  always @(posedge clk) begin
    m_err = !ok_pair(int'(freq_in), int'(dmode_in));
    if (rst) begin
      if (ok_pair(int'(freq_in), int'(dmode_in))) begin
        m_f = int'(freq_in); m_h = hi_of(int'(freq_in), int'(dmode_in));
      end else begin
        m_f = 8; m_h = 4;
      end
      m_t = '0; m_out = 1'b0;
      m_rise = AW'(m_f); m_fall = AW'(m_f + m_h);
    end else begin
      if (m_t == m_rise) begin
        m_out = 1'b1;
        if (ok_pair(int'(freq_in), int'(dmode_in))) begin
          m_f = int'(freq_in); m_h = hi_of(int'(freq_in), int'(dmode_in));
        end
        m_fall = m_rise + AW'(m_h);
        m_rise = m_rise + AW'(m_f);
      end else if (m_t == m_fall) begin
        m_out = 1'b0;
      end
      m_t = m_t + AW'(1);
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      check(clk_out == m_out, "R2/R3 level", int'(clk_out), int'(m_out));
      check(sel_rise == m_rise[2:0], "R5 sel_rise", int'(sel_rise), int'(m_rise[2:0]));
      check(sel_fall == m_fall[2:0], "R5 sel_fall", int'(sel_fall), int'(m_fall[2:0]));
      check(cfg_err == m_err, "R8 cfg_err", int'(cfg_err), int'(m_err));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wait_rise();
    bit prev;
    prev = clk_out;
    forever begin
      @(negedge clk);
      if (clk_out && !prev) break;
      prev = clk_out;
    end
  endtask

  // drive a pair, then measure the period begun by the next rise
  task automatic apply(int f, int d, int exp_h, int exp_p, string tag);
    int hi, lo;
    freq_in = 4'(f); dmode_in = 3'(d);
    wait_rise();
    hi = 1;
    forever begin @(negedge clk); if (clk_out) hi++; else break; end
    lo = 1;
    forever begin @(negedge clk); if (!clk_out) lo++; else break; end
    check(hi == exp_h, {tag, " high time"}, hi, exp_h);
    check(hi + lo == exp_p, {tag, " period"}, hi + lo, exp_p);
  endtask

  int cur_f = 8, cur_h = 3;

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: F=8, D=1 -> rise step 8 (sel 0), fall step 11 (sel 3)
    check(clk_out == 1'b0, "R1 out low", int'(clk_out), 0);
    check(sel_rise == 3'd0, "R1 sel_rise", int'(sel_rise), 0);
    check(sel_fall == 3'd3, "R1 sel_fall", int'(sel_fall), 3);
    check(cfg_err == 1'b0, "R1 err", int'(cfg_err), 0);
    rst = 1'b0; chk_en = 1'b1;
    begin : first_rise_r4
      int n;
      n = 0;
      forever begin @(negedge clk); n++; if (clk_out || n > 40) break; end
      check(n == 9, "R4 first rise edge", n, 9);
    end

    apply(15, 1, 6, 15, "R3 F15D1");
    apply(2, 0, 1, 2, "R2 F2");
    apply(3, 0, 1, 3, "R2 F3");
    apply(14, 6, 1, 14, "R3 F14D6");
    apply(15, 0, 7, 15, "R3 F15D0");
    apply(8, 0, 4, 8, "R2 F8");
    // R7: illegal pairs keep F=8, high 4
    freq_in = 4'd4; dmode_in = 3'd2;
    @(negedge clk);
    check(cfg_err == 1'b1, "R8 err raised", int'(cfg_err), 1);
    apply(4, 2, 4, 8, "R7 F4D2");
    apply(1, 0, 4, 8, "R7 F1");
    apply(3, 1, 4, 8, "R7 F3D1");
    apply(0, 0, 4, 8, "R7 F0");
    apply(12, 0, 6, 12, "R2 F12");
    // R6: change inputs two steps into a period; high time stays 6
    begin : mid_change_r6
      int n;
      wait_rise();
      n = 1;
      repeat (2) begin @(negedge clk); if (clk_out) n++; end
      freq_in = 4'd5; dmode_in = 3'd1;
      forever begin @(negedge clk); if (clk_out) n++; else break; end
      check(n == 6, "R6 mid-period hold", n, 6);
    end
    apply(5, 1, 1, 5, "R6 next period");
    cur_f = 5; cur_h = 1;

    for (int i = 0; i < 80; i++) begin
      int f, d;
      f = 2 + int'($urandom % 14);
      d = int'($urandom % 8);
      if (ok_pair(f, d)) begin cur_f = f; cur_h = hi_of(f, d); end
      apply(f, d, cur_h, cur_f, "R2/R3/R7 random");
    end

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule